// File: doc/BRIEF.md
# Flash Sector Lock Controller

This block guards an embedded flash array against unwanted program and erase activity. It keeps two 16-bit lock fields for the low address space, a primary and a secondary. Each field comes up from its own non-volatile default word during reset. The effective protection of a sector is the OR of its bit in the two fields. Firmware may change the fields through a small write port. A write is accepted only when the lock-enable bit is set and the flash is neither busy with an operation nor suspended.

A parameter sets how many sectors the array implements. The positions above that count are tied to 1: they cannot be written and they ignore the non-volatile word. A program or erase request names a sector. One cycle later the block either raises that sector's pulse enable or, if the sector is protected, raises a one-cycle error flag.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The effective lock of a sector is the OR of its primary and secondary bits. It drives `lock_vec` and reads back with `rd_sel` = 3.
- R2: While `rst_n` is low, on each clock edge the primary field loads from `nv_pri` and the secondary field loads from `nv_sec`. A later reset does the same again.
- R3: With all-ones defaults on both non-volatile words, every sector leaves reset locked and `lock_vec` is all ones.
- R4: Bit positions at or above `NUM_SECT` read 1 in both fields and in `lock_vec`, whatever the non-volatile words hold and whatever a write carries.
- R5: The lock-enable bit (control word, `wr_sel` = 0, data bit 0) clears on reset. While it is 0, writes to the fields (`wr_sel` = 1 primary, `wr_sel` = 2 secondary, data bits 15:0) have no effect.
- R6: Field writes are ignored from the cycle `op_start` is high until the cycle after the one in which `op_done` is seen.
- R7: Field writes are ignored in any cycle in which `op_suspend` is high.
- R8: A request (`pe_req` with `pe_sect`) to a sector whose effective lock is 0 sets exactly that sector's `pe_grant` bit in the next cycle, with `lock_err` low.
- R9: A request to a sector whose effective lock is 1, including an absent sector, raises `lock_err` for one cycle in the next cycle, with `pe_grant` all zero.
- R10: Readback selects: 0 gives the enable bit in bit 0, 1 gives the primary field, 2 gives the secondary field, 3 gives the effective lock. In every case the unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the non-volatile defaults |
| nv_pri | input | 16 | Non-volatile default for the primary field |
| nv_sec | input | 16 | Non-volatile default for the secondary field |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 primary, 2 secondary |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Readback select |
| rd_data | output | 32 | Readback data |
| op_start | input | 1 | Interlock write that starts a program/erase operation |
| op_done | input | 1 | Operation-complete flag |
| op_suspend | input | 1 | High-voltage operation suspended |
| pe_req | input | 1 | Program/erase pulse request |
| pe_sect | input | 4 | Sector index of the request |
| pe_grant | output | NUM_SECT | Per-sector pulse enable, registered |
| lock_err | output | 1 | Request hit a locked sector, one-cycle pulse |
| lock_vec | output | 16 | Effective per-sector lock |

## Verification
A wrong field bit appears on `lock_vec` and on readback select 3 in the cycle right after the faulty write or reset load. It also flips the grant/error outcome of the next request to that sector one cycle later. A stuck busy or enable flag shows first as a write that lands or is lost, and readback of the field shows it in the next cycle. Absent positions are watched every cycle, because a dropped force value would unlock a sector that does not exist.

// File: rtl/flock_pkg.sv
package flock_pkg;
  localparam int LOCK_W = 16;
  localparam int SEL_W  = $clog2(LOCK_W);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PRI  = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_EFF  = 2'd3
  } reg_sel_e;

  // Positions at or above the sector count are held at 1.
  function automatic logic [LOCK_W-1:0] force_absent(input logic [LOCK_W-1:0] v,
                                                     input int n_sect);
    logic [LOCK_W-1:0] r;
    for (int i = 0; i < LOCK_W; i++) r[i] = (i >= n_sect) ? 1'b1 : v[i];
    return r;
  endfunction

  function automatic logic [LOCK_W-1:0] combine_locks(input logic [LOCK_W-1:0] a,
                                                      input logic [LOCK_W-1:0] b);
    return a | b;
  endfunction
endpackage

// File: rtl/flock_field.sv
module flock_field
  import flock_pkg::*;
#(
  parameter int NUM_SECT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] nv_val,
  input  logic              wr_hit,
  input  logic              wr_ok,
  input  logic [LOCK_W-1:0] wr_val,
  output logic [LOCK_W-1:0] field
);
  logic [LOCK_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      field_q <= force_absent(nv_val, NUM_SECT);
    else if (wr_hit && wr_ok)
      field_q <= force_absent(wr_val, NUM_SECT);
  end

  assign field = field_q;
endmodule

// File: rtl/flock_gate.sv
module flock_gate
  import flock_pkg::*;
#(
  parameter int NUM_SECT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] eff_lock,
  input  logic              pe_req,
  input  logic [SEL_W-1:0]  pe_sect,
  output logic [NUM_SECT-1:0] pe_grant,
  output logic              lock_err
);
  logic                sel_locked;
  logic [NUM_SECT-1:0] grant_d;

  assign sel_locked = eff_lock[pe_sect];

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    assign grant_d[g] = pe_req && !sel_locked && (pe_sect == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_grant <= '0;
      lock_err <= 1'b0;
    end else begin
      pe_grant <= grant_d;
      lock_err <= pe_req && sel_locked;
    end
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flock_pkg::*;
#(
  parameter int NUM_SECT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          nv_pri,
  input  logic [15:0]          nv_sec,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [31:0]          wr_data,
  input  logic [1:0]           rd_sel,
  output logic [31:0]          rd_data,
  input  logic                 op_start,
  input  logic                 op_done,
  input  logic                 op_suspend,
  input  logic                 pe_req,
  input  logic [3:0]           pe_sect,
  output logic [NUM_SECT-1:0]  pe_grant,
  output logic                 lock_err,
  output logic [15:0]          lock_vec
);
  logic              lock_en_q;
  logic              busy_q;
  logic              wr_blocked;
  logic              wr_ok;
  logic [LOCK_W-1:0] pri_q;
  logic [LOCK_W-1:0] sec_q;
  logic [LOCK_W-1:0] eff_lock;

  // Event wires shared with the checker.
  assign wr_blocked = busy_q || op_start || op_suspend;
  assign wr_ok      = lock_en_q && !wr_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_en_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_CTRL) lock_en_q <= wr_data[0];
      if (op_start)     busy_q <= 1'b1;
      else if (op_done) busy_q <= 1'b0;
    end
  end

  flock_field #(.NUM_SECT(NUM_SECT)) u_pri (
    .clk(clk), .rst_n(rst_n), .nv_val(nv_pri),
    .wr_hit(wr_en && wr_sel == SEL_PRI), .wr_ok(wr_ok),
    .wr_val(wr_data[LOCK_W-1:0]), .field(pri_q)
  );

  flock_field #(.NUM_SECT(NUM_SECT)) u_sec (
    .clk(clk), .rst_n(rst_n), .nv_val(nv_sec),
    .wr_hit(wr_en && wr_sel == SEL_SEC), .wr_ok(wr_ok),
    .wr_val(wr_data[LOCK_W-1:0]), .field(sec_q)
  );

  assign eff_lock = combine_locks(pri_q, sec_q);
  assign lock_vec = eff_lock;

  flock_gate #(.NUM_SECT(NUM_SECT)) u_gate (
    .clk(clk), .rst_n(rst_n), .eff_lock(eff_lock),
    .pe_req(pe_req), .pe_sect(pe_sect),
    .pe_grant(pe_grant), .lock_err(lock_err)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data = {31'd0, lock_en_q};
      SEL_PRI:  rd_data = {16'd0, pri_q};
      SEL_SEC:  rd_data = {16'd0, sec_q};
      default:  rd_data = {16'd0, eff_lock};
    endcase
  end
endmodule

// File: rtl/flock_chk.sv
module flock_chk #(
  parameter int NUM_SECT = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_blocked,
  input logic                lock_en_q,
  input logic [15:0]         pri_q,
  input logic [15:0]         sec_q,
  input logic [15:0]         lock_vec,
  input logic                pe_req,
  input logic [3:0]          pe_sect,
  input logic [NUM_SECT-1:0] pe_grant,
  input logic                lock_err
);
  // R4: absent positions stay locked in both fields
  p_absent_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&pri_q[15:NUM_SECT]) && (&sec_q[15:NUM_SECT]) && (&lock_vec[15:NUM_SECT]));

  // R5: no enable, no field change
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en_q |=> $stable(pri_q) && $stable(sec_q));

  // R6 / R7: busy or suspended blocks field writes
  p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(pri_q) && $stable(sec_q));

  // R8: unlocked request yields one grant, no error
  p_grant_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req && !lock_vec[pe_sect] |=> ($countones(pe_grant) == 1) && !lock_err);

  // R9: locked request yields error only
  p_err_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req && lock_vec[pe_sect] |=> lock_err && (pe_grant == '0));

  // R8: at most one pulse enable at a time
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pe_grant));

  // R1: effective lock covers both fields
  p_or_cover_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_q | sec_q) & ~lock_vec) == 16'd0);
endmodule

bind flash_lock_ctrl flock_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_blocked(wr_blocked), .lock_en_q(lock_en_q),
  .pri_q(pri_q), .sec_q(sec_q), .lock_vec(lock_vec), .pe_req(pe_req),
  .pe_sect(pe_sect), .pe_grant(pe_grant), .lock_err(lock_err)
);

// File: tb/sim_flash_lock_ctrl.sv
`timescale 1ns/1ps
module sim_flash_lock_ctrl;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] nv_pri, nv_sec;
  logic wr_en;
  logic [1:0] wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic op_start, op_done, op_suspend, pe_req;
  logic [3:0] pe_sect;
  logic [NS-1:0] pe_grant;
  logic lock_err;
  logic [15:0] lock_vec;

  flash_lock_ctrl #(.NUM_SECT(NS)) u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Model state
  logic [15:0] m_pri, m_sec;
  logic m_en, m_busy;

  function automatic logic [15:0] fix(input logic [15:0] v);
    return v | ~((16'd1 << NS) - 16'd1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [15:0] p, input logic [15:0] s);
    @(negedge clk);
    rst_n = 0; nv_pri = p; nv_sec = s;
    wr_en = 0; op_start = 0; op_done = 0; op_suspend = 0; pe_req = 0;
    @(posedge clk); #1;
    m_pri = fix(p); m_sec = fix(s); m_en = 0; m_busy = 0;
    @(negedge clk); rst_n = 1;
    nv_pri = ~p; nv_sec = ~s; // later values must not matter
  endtask

  // One cycle of stimulus, model update and output check.
  task automatic step(input logic w, input logic [1:0] ws, input logic [31:0] wd,
                      input logic st, input logic dn, input logic su,
                      input logic rq, input logic [3:0] sc, input logic [1:0] rs);
    logic [15:0] eff;
    logic ok;
    logic [NS-1:0] exp_g;
    logic exp_e;
    @(negedge clk);
    wr_en = w; wr_sel = ws; wr_data = wd; op_start = st; op_done = dn;
    op_suspend = su; pe_req = rq; pe_sect = sc; rd_sel = rs;
    eff = m_pri | m_sec;
    exp_e = rq && eff[sc];
    exp_g = '0;
    if (rq && !eff[sc]) exp_g[sc[2:0]] = 1'b1;
    ok = m_en && !m_busy && !st && !su;
    if (w && ws == 2'd1 && ok) m_pri = fix(wd[15:0]);
    if (w && ws == 2'd2 && ok) m_sec = fix(wd[15:0]);
    if (w && ws == 2'd0) m_en = wd[0];
    if (st) m_busy = 1; else if (dn) m_busy = 0;
    @(posedge clk); #1;
    check("R8", {26'd0, pe_grant}, {26'd0, exp_g});
    check("R9", {31'd0, lock_err}, {31'd0, exp_e});
    check("R1", {16'd0, lock_vec}, {16'd0, m_pri | m_sec});
    case (rs)
      2'd0: check("R10", rd_data, {31'd0, m_en});
      2'd1: check("R10", rd_data, {16'd0, m_pri});
      2'd2: check("R10", rd_data, {16'd0, m_sec});
      default: check("R10", rd_data, {16'd0, m_pri | m_sec});
    endcase
  endtask

  task automatic rd(input logic [1:0] rs, input string req, input logic [31:0] exp);
    @(negedge clk); wr_en = 0; pe_req = 0; op_start = 0; op_done = 0;
    op_suspend = 0; rd_sel = rs; #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    op_start = 0; op_done = 0; op_suspend = 0; pe_req = 0; pe_sect = 0;
    nv_pri = 0; nv_sec = 0;

    // R3: erased defaults lock all
    do_reset(16'hFFFF, 16'hFFFF);
    check("R3", {16'd0, lock_vec}, 32'h0000FFFF);
    rd(2'd0, "R5", 32'd0);
    // R2: defaults loaded
    do_reset(16'h0005, 16'h0010);
    rd(2'd1, "R2", {16'd0, fix(16'h0005)});
    rd(2'd2, "R2", {16'd0, fix(16'h0010)});
    // R4: absent positions forced even with zero defaults
    do_reset(16'h0000, 16'h0000);
    check("R4", {16'd0, lock_vec}, {16'd0, fix(16'h0)});
    // R5: write without enable ignored
    step(1, 2'd1, 32'h0000_003F, 0, 0, 0, 0, 0, 2'd1);
    rd(2'd1, "R5", {16'd0, fix(16'h0)});
    step(1, 2'd0, 32'd1, 0, 0, 0, 0, 0, 2'd0);
    // R4: write clearing absent bits
    step(1, 2'd1, 32'h0000_0002, 0, 0, 0, 0, 0, 2'd1);
    rd(2'd1, "R4", {16'd0, fix(16'h0002)});
    // R8/R9 directed
    step(0, 0, 0, 0, 0, 0, 1, 4'd0, 2'd3);
    step(0, 0, 0, 0, 0, 0, 1, 4'd1, 2'd3);
    step(0, 0, 0, 0, 0, 0, 1, 4'd9, 2'd3);
    // R6: blocked from start to done
    step(1, 2'd2, 32'h0000_0001, 1, 0, 0, 0, 0, 2'd2);
    step(1, 2'd2, 32'h0000_0001, 0, 0, 0, 0, 0, 2'd2);
    step(1, 2'd2, 32'h0000_0001, 0, 1, 0, 0, 0, 2'd2);
    rd(2'd2, "R6", {16'd0, fix(16'h0)});
    step(1, 2'd2, 32'h0000_0001, 0, 0, 0, 0, 0, 2'd2);
    rd(2'd2, "R6", {16'd0, fix(16'h0001)});
    // R7: suspended
    step(1, 2'd2, 32'h0000_0020, 0, 0, 1, 0, 0, 2'd2);
    rd(2'd2, "R7", {16'd0, fix(16'h0001)});
    // R2: later reset reloads
    do_reset(16'h0003, 16'h0000);
    rd(2'd1, "R2", {16'd0, fix(16'h0003)});

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], {16'd0, 16'($urandom)},
           (r[7:4] == 0), (r[10:8] == 0), (r[14:11] == 0),
           r[15], r[19:16], r[21:20]);
      if (r[31:22] == 0) do_reset(16'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule